// File: doc/BRIEF.md
# Out-of-Order Reservation Station with Condition-Code Renaming

This block holds decoded instructions between in-order issue and out-of-order dispatch. Each accepted instruction takes a slot, and the slot number becomes that instruction's producer tag. For every source register, the slot records whether the value is still outstanding and which tag will supply it. A condition-code read is handled the same way. One global register remembers the tag of the youngest issued instruction that writes the condition code, and a reader waits on that tag exactly as it would wait on a register producer.

An issue group of up to `LANES` instructions arrives each cycle. Lane 0 is the oldest in program order. Inside a group, a later lane sees the destinations and flag writes of earlier lanes.

Each cycle the station sends at most one ready slot to its functional unit, and the oldest ready slot goes first. A write-back broadcast carries a tag and a bit saying whether that instruction wrote the condition code. The broadcast wakes every waiter on that tag, clears the register and flag trackers if they still point at it, and returns the producer's slot to the free pool.

Top module: `rs_flagtag_station`

## Requirements
- R1: After reset every slot is free, `grp_room` is 1, `disp_valid` is 0 and `flag_busy` is 0.
- R2: Lane l of a group takes the (l+1)-th lowest-numbered free slot, so lane 0 always gets the lowest one. The slot number is the instruction's tag. `grp_room` is 1 exactly when at least `LANES` slots are free.
- R3: On insertion, each used source (operand a and operand b) waits on the tag that the register tracker holds for that register. If an earlier lane in the same group writes that register, the source waits on that lane's slot instead. The tracker keeps the youngest writer, and a broadcast of an older writer's tag does not clear it.
- R4: A source or flag whose producer tag is broadcast in the very cycle of insertion is recorded as already resolved.
- R5: A broadcast of tag T clears every register wait on T. A slot whose waits are all cleared can be dispatched from the next cycle on.
- R6: An instruction that reads the condition code waits on the tag held in the flag register, or on an earlier lane of its group that writes the condition code. This wait is cleared only by a broadcast of that tag with `wb_wr_flag` = 1.
- R7: An inserted condition-code writer sets `flag_busy` = 1 and `flag_tag` = its slot, and the last such lane of a group wins. A broadcast of `flag_tag` with `wb_wr_flag` = 1 clears `flag_busy`, unless a new writer is inserted in the same cycle.
- R8: At most one instruction is dispatched per cycle. Only a slot that is waiting on nothing is dispatched, and it then stays held until its write-back.
- R9: When several slots are ready, the one inserted earliest in program order is dispatched. This holds regardless of slot numbers.
- R10: A write-back of tag T frees slot T on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | LANES | Lane holds an instruction (lane 0 oldest) |
| grp_src_a | input | LANES x REG_W | Operand a register |
| grp_use_a | input | LANES | Operand a is read |
| grp_src_b | input | LANES x REG_W | Operand b register |
| grp_use_b | input | LANES | Operand b is read |
| grp_dst | input | LANES x REG_W | Destination register |
| grp_wr_dst | input | LANES | Destination is written |
| grp_rd_flag | input | LANES | Instruction reads the condition code |
| grp_wr_flag | input | LANES | Instruction writes the condition code |
| grp_room | output | 1 | At least LANES slots free; a group may be sent |
| wb_valid | input | 1 | Write-back broadcast this cycle |
| wb_tag | input | TAG_W | Tag being written back |
| wb_wr_flag | input | 1 | Written-back instruction produced the condition code |
| disp_valid | output | 1 | A slot is dispatched at this edge |
| disp_tag | output | TAG_W | Slot being dispatched |
| flag_busy | output | 1 | A condition-code writer is outstanding |
| flag_tag | output | TAG_W | Tag of the youngest outstanding condition-code writer |

## Verification
The bound checker watches several rules on every cycle: that a dispatched slot has no open waits and then becomes held, that a written-back slot becomes free, and that the flag register releases when its own producer returns with no new writer arriving. The remaining behaviour needs the bench's scenarios to show it. That covers oldest-first choice when a younger instruction sits in a lower slot, the capture of a broadcast in the insertion cycle, the forwarding of dependencies between lanes of one group, and a tracker left pointing at the younger of two writers of the same register.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ISSUED = 2'd2
  } ent_st_e;
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter  int ENTRIES = 4,
  parameter  int LANES   = 2,
  localparam int TAG_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]          free_i,
  output logic [LANES-1:0][TAG_W-1:0] slot_o,
  output logic                        room_o
);
  logic [ENTRIES-1:0] left;

  // Each lane takes the lowest slot still left after the earlier lanes.
  always_comb begin
    left   = free_i;
    slot_o = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (left[e]) slot_o[l] = TAG_W'(e);
      end
      left[slot_o[l]] = 1'b0;
    end
  end

  assign room_o = ($countones(free_i) >= LANES);
endmodule

// File: rtl/rs_rename.sv
module rs_rename #(
  parameter  int ENTRIES  = 4,
  parameter  int NUM_REGS = 8,
  parameter  int LANES    = 2,
  localparam int TAG_W    = $clog2(ENTRIES),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            ins_v,
  input  logic [LANES-1:0][TAG_W-1:0] slot,
  input  logic [LANES-1:0][REG_W-1:0] src_a,
  input  logic [LANES-1:0]            use_a,
  input  logic [LANES-1:0][REG_W-1:0] src_b,
  input  logic [LANES-1:0]            use_b,
  input  logic [LANES-1:0][REG_W-1:0] dst,
  input  logic [LANES-1:0]            wr_dst,
  input  logic [LANES-1:0]            rd_flag,
  input  logic [LANES-1:0]            wr_flag,
  input  logic                        wb_valid,
  input  logic [TAG_W-1:0]            wb_tag,
  input  logic                        wb_wr_flag,
  output logic [LANES-1:0]            wait_a,
  output logic [LANES-1:0][TAG_W-1:0] tag_a,
  output logic [LANES-1:0]            wait_b,
  output logic [LANES-1:0][TAG_W-1:0] tag_b,
  output logic [LANES-1:0]            wait_f,
  output logic [LANES-1:0][TAG_W-1:0] tag_f,
  output logic                        flag_busy_o,
  output logic [TAG_W-1:0]            flag_tag_o
);
  logic [NUM_REGS-1:0]            busy_q, busy_d;
  logic [NUM_REGS-1:0][TAG_W-1:0] ptag_q, ptag_d;
  logic                           fbusy_q, fbusy_d;
  logic [TAG_W-1:0]               ftag_q, ftag_d;

  // Lookup: tracker state, minus a same-cycle broadcast, overridden by earlier lanes.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      tag_a[l]  = ptag_q[src_a[l]];
      wait_a[l] = use_a[l] && busy_q[src_a[l]] && !(wb_valid && wb_tag == ptag_q[src_a[l]]);
      tag_b[l]  = ptag_q[src_b[l]];
      wait_b[l] = use_b[l] && busy_q[src_b[l]] && !(wb_valid && wb_tag == ptag_q[src_b[l]]);
      tag_f[l]  = ftag_q;
      wait_f[l] = rd_flag[l] && fbusy_q && !(wb_valid && wb_wr_flag && wb_tag == ftag_q);
      for (int k = 0; k < l; k++) begin
        if (ins_v[k] && wr_dst[k] && use_a[l] && dst[k] == src_a[l]) begin
          wait_a[l] = 1'b1;
          tag_a[l]  = slot[k];
        end
        if (ins_v[k] && wr_dst[k] && use_b[l] && dst[k] == src_b[l]) begin
          wait_b[l] = 1'b1;
          tag_b[l]  = slot[k];
        end
        if (ins_v[k] && wr_flag[k] && rd_flag[l]) begin
          wait_f[l] = 1'b1;
          tag_f[l]  = slot[k];
        end
      end
    end
  end

  // Next state: release on matching broadcast, then newer writers take over.
  always_comb begin
    busy_d  = busy_q;
    ptag_d  = ptag_q;
    fbusy_d = fbusy_q;
    ftag_d  = ftag_q;
    if (wb_valid) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (busy_q[r] && ptag_q[r] == wb_tag) busy_d[r] = 1'b0;
      end
      if (wb_wr_flag && fbusy_q && ftag_q == wb_tag) fbusy_d = 1'b0;
    end
    for (int l = 0; l < LANES; l++) begin
      if (ins_v[l] && wr_dst[l]) begin
        busy_d[dst[l]] = 1'b1;
        ptag_d[dst[l]] = slot[l];
      end
      if (ins_v[l] && wr_flag[l]) begin
        fbusy_d = 1'b1;
        ftag_d  = slot[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      ptag_q  <= '0;
      fbusy_q <= 1'b0;
      ftag_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      ptag_q  <= ptag_d;
      fbusy_q <= fbusy_d;
      ftag_q  <= ftag_d;
    end
  end

  assign flag_busy_o = fbusy_q;
  assign flag_tag_o  = ftag_q;
endmodule

// File: rtl/rs_age.sv
module rs_age #(
  parameter  int ENTRIES = 4,
  parameter  int LANES   = 2,
  localparam int TAG_W   = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            ins_v,
  input  logic [LANES-1:0][TAG_W-1:0] slot,
  input  logic [ENTRIES-1:0]          occ_i,
  input  logic [ENTRIES-1:0]          ready_i,
  output logic                        pick_v,
  output logic [TAG_W-1:0]            pick_idx
);
  // older_q[i][j] = 1 when slot j holds an instruction older than slot i.
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q, older_d;

  always_comb begin
    older_d = older_q;
    for (int l = 0; l < LANES; l++) begin
      if (ins_v[l]) begin
        for (int k = 0; k < ENTRIES; k++) older_d[k][slot[l]] = 1'b0;
        older_d[slot[l]] = occ_i;
        for (int m = 0; m < l; m++) begin
          if (ins_v[m]) older_d[slot[l]][slot[m]] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= '0;
    else if (|ins_v) older_q <= older_d;
  end

  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ready_i[i] && !(|(ready_i & older_q[i]))) begin
        pick_v   = 1'b1;
        pick_idx = TAG_W'(i);
      end
    end
  end
endmodule

// File: rtl/rs_flagtag_station.sv
module rs_flagtag_station #(
  parameter  int ENTRIES  = 4,
  parameter  int NUM_REGS = 8,
  parameter  int LANES    = 2,
  localparam int TAG_W    = $clog2(ENTRIES),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            grp_valid,
  input  logic [LANES-1:0][REG_W-1:0] grp_src_a,
  input  logic [LANES-1:0]            grp_use_a,
  input  logic [LANES-1:0][REG_W-1:0] grp_src_b,
  input  logic [LANES-1:0]            grp_use_b,
  input  logic [LANES-1:0][REG_W-1:0] grp_dst,
  input  logic [LANES-1:0]            grp_wr_dst,
  input  logic [LANES-1:0]            grp_rd_flag,
  input  logic [LANES-1:0]            grp_wr_flag,
  output logic                        grp_room,
  input  logic                        wb_valid,
  input  logic [TAG_W-1:0]            wb_tag,
  input  logic                        wb_wr_flag,
  output logic                        disp_valid,
  output logic [TAG_W-1:0]            disp_tag,
  output logic                        flag_busy,
  output logic [TAG_W-1:0]            flag_tag
);
  import rs_pkg::*;

  ent_st_e [ENTRIES-1:0]            st_q, st_d;
  logic    [ENTRIES-1:0]            wa_q, wa_d, wb_q, wb_d, wf_q, wf_d;
  logic    [ENTRIES-1:0][TAG_W-1:0] ta_q, ta_d, tb_q, tb_d, tf_q, tf_d;
  logic    [ENTRIES-1:0]            free_v, ready_v;
  logic    [LANES-1:0][TAG_W-1:0]   slot;
  logic    [LANES-1:0]              lk_wa, lk_wb, lk_wf;
  logic    [LANES-1:0][TAG_W-1:0]   lk_ta, lk_tb, lk_tf;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      free_v[i]  = (st_q[i] == ST_FREE);
      ready_v[i] = (st_q[i] == ST_WAIT) && !wa_q[i] && !wb_q[i] && !wf_q[i];
    end
  end

  rs_alloc #(.ENTRIES(ENTRIES), .LANES(LANES)) u_alloc (
    .free_i (free_v),
    .slot_o (slot),
    .room_o (grp_room)
  );

  rs_rename #(.ENTRIES(ENTRIES), .NUM_REGS(NUM_REGS), .LANES(LANES)) u_rename (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_v       (grp_valid),
    .slot        (slot),
    .src_a       (grp_src_a),
    .use_a       (grp_use_a),
    .src_b       (grp_src_b),
    .use_b       (grp_use_b),
    .dst         (grp_dst),
    .wr_dst      (grp_wr_dst),
    .rd_flag     (grp_rd_flag),
    .wr_flag     (grp_wr_flag),
    .wb_valid    (wb_valid),
    .wb_tag      (wb_tag),
    .wb_wr_flag  (wb_wr_flag),
    .wait_a      (lk_wa),
    .tag_a       (lk_ta),
    .wait_b      (lk_wb),
    .tag_b       (lk_tb),
    .wait_f      (lk_wf),
    .tag_f       (lk_tf),
    .flag_busy_o (flag_busy),
    .flag_tag_o  (flag_tag)
  );

  rs_age #(.ENTRIES(ENTRIES), .LANES(LANES)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_v    (grp_valid),
    .slot     (slot),
    .occ_i    (~free_v),
    .ready_i  (ready_v),
    .pick_v   (disp_valid),
    .pick_idx (disp_tag)
  );

  // Slot next state: wake-up, dispatch, release, then fresh insertions.
  always_comb begin
    st_d = st_q;
    wa_d = wa_q; ta_d = ta_q;
    wb_d = wb_q; tb_d = tb_q;
    wf_d = wf_q; tf_d = tf_q;
    if (wb_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wa_q[i] && ta_q[i] == wb_tag) wa_d[i] = 1'b0;
        if (wb_q[i] && tb_q[i] == wb_tag) wb_d[i] = 1'b0;
        if (wf_q[i] && wb_wr_flag && tf_q[i] == wb_tag) wf_d[i] = 1'b0;
      end
    end
    if (disp_valid) st_d[disp_tag] = ST_ISSUED;
    if (wb_valid) st_d[wb_tag] = ST_FREE;
    for (int l = 0; l < LANES; l++) begin
      if (grp_valid[l]) begin
        st_d[slot[l]] = ST_WAIT;
        wa_d[slot[l]] = lk_wa[l]; ta_d[slot[l]] = lk_ta[l];
        wb_d[slot[l]] = lk_wb[l]; tb_d[slot[l]] = lk_tb[l];
        wf_d[slot[l]] = lk_wf[l]; tf_d[slot[l]] = lk_tf[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= {ENTRIES{ST_FREE}};
      wa_q <= '0; ta_q <= '0;
      wb_q <= '0; tb_q <= '0;
      wf_q <= '0; tf_q <= '0;
    end else begin
      st_q <= st_d;
      wa_q <= wa_d; ta_q <= ta_d;
      wb_q <= wb_d; tb_q <= tb_d;
      wf_q <= wf_d; tf_q <= tf_d;
    end
  end
endmodule

// File: rtl/rs_flagtag_station_chk.sv
module rs_flagtag_station_chk #(
  parameter  int ENTRIES = 4,
  parameter  int LANES   = 2,
  localparam int TAG_W   = $clog2(ENTRIES)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           disp_valid,
  input logic [TAG_W-1:0]               disp_tag,
  input logic                           wb_valid,
  input logic [TAG_W-1:0]               wb_tag,
  input logic                           wb_wr_flag,
  input logic                           flag_busy,
  input logic [TAG_W-1:0]               flag_tag,
  input logic [LANES-1:0]               grp_valid,
  input logic [LANES-1:0]               grp_wr_flag,
  input rs_pkg::ent_st_e [ENTRIES-1:0]  st_q,
  input logic [ENTRIES-1:0]             wa_q,
  input logic [ENTRIES-1:0]             wb_q,
  input logic [ENTRIES-1:0]             wf_q
);
  import rs_pkg::*;

  AST_DISP_ONLY_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (st_q[disp_tag] == ST_WAIT && !wa_q[disp_tag] && !wb_q[disp_tag] && !wf_q[disp_tag])); // R8

  AST_DISP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !(wb_valid && wb_tag == disp_tag)) |=> st_q[$past(disp_tag)] == ST_ISSUED); // R8

  AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> st_q[$past(wb_tag)] == ST_FREE); // R10

  AST_FLAG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_wr_flag && flag_busy && flag_tag == wb_tag && !(|(grp_valid & grp_wr_flag)))
      |=> !flag_busy); // R7
endmodule

bind rs_flagtag_station rs_flagtag_station_chk #(.ENTRIES(ENTRIES), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_valid  (disp_valid),
  .disp_tag    (disp_tag),
  .wb_valid    (wb_valid),
  .wb_tag      (wb_tag),
  .wb_wr_flag  (wb_wr_flag),
  .flag_busy   (flag_busy),
  .flag_tag    (flag_tag),
  .grp_valid   (grp_valid),
  .grp_wr_flag (grp_wr_flag),
  .st_q        (st_q),
  .wa_q        (wa_q),
  .wb_q        (wb_q),
  .wf_q        (wf_q)
);

// File: tb/rs_flagtag_station_test.sv
module rs_flagtag_station_test;
  localparam int ENTRIES = 4;
  localparam int NUM_REGS = 8;
  localparam int LANES = 2;
  localparam int TAG_W = 2;
  localparam int REG_W = 3;
  localparam int NROWS = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic [LANES-1:0]            grp_valid, grp_use_a, grp_use_b, grp_wr_dst, grp_rd_flag, grp_wr_flag;
  logic [LANES-1:0][REG_W-1:0] grp_src_a, grp_src_b, grp_dst;
  logic                        grp_room;
  logic                        wb_valid, wb_wr_flag;
  logic [TAG_W-1:0]            wb_tag;
  logic                        disp_valid, flag_busy;
  logic [TAG_W-1:0]            disp_tag, flag_tag;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rs_flagtag_station #(.ENTRIES(ENTRIES), .NUM_REGS(NUM_REGS), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n),
    .grp_valid(grp_valid), .grp_src_a(grp_src_a), .grp_use_a(grp_use_a),
    .grp_src_b(grp_src_b), .grp_use_b(grp_use_b), .grp_dst(grp_dst),
    .grp_wr_dst(grp_wr_dst), .grp_rd_flag(grp_rd_flag), .grp_wr_flag(grp_wr_flag),
    .grp_room(grp_room), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_wr_flag(wb_wr_flag),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .flag_busy(flag_busy), .flag_tag(flag_tag)
  );

  // Lane word: {valid, use_a, src_a[3], use_b, src_b[3], wr_dst, dst[3], rd_flag, wr_flag}
  function automatic logic [14:0] mk(input logic v, input logic ua, input logic [2:0] sa,
                                     input logic ub, input logic [2:0] sb, input logic wd,
                                     input logic [2:0] d, input logic rf, input logic wf);
    return {v, ua, sa, ub, sb, wd, d, rf, wf};
  endfunction

  localparam logic [14:0] NOP = 15'd0;
  // Row: {lane0, lane1, wb{v,tag,flag}, expect{disp_v, disp_tag, flag_busy, flag_tag}}
  localparam logic [39:0] SCRIPT [NROWS] = '{
    {mk(1,0,0,0,0,1,1,0,1), NOP,                   4'b0000, 6'b100100},
    {mk(1,1,1,0,0,1,2,1,0), mk(1,1,2,0,0,0,0,0,0), 4'b0000, 6'b000100},
    {NOP,                   NOP,                   4'b1001, 6'b101000},
    {NOP,                   NOP,                   4'b0000, 6'b000000},
    {mk(1,1,2,0,0,0,0,0,1), NOP,                   4'b1010, 6'b110100},
    {NOP,                   NOP,                   4'b0000, 6'b100100},
    {mk(1,0,0,0,0,0,0,1,1), NOP,                   4'b0000, 6'b000101},
    {NOP,                   NOP,                   4'b1001, 6'b101101},
    {NOP,                   NOP,                   4'b1100, 6'b000101},
    {NOP,                   NOP,                   4'b1011, 6'b000000},
    {mk(1,0,0,0,0,0,0,0,1), NOP,                   4'b0000, 6'b100100},
    {mk(1,0,0,0,0,0,0,0,1), NOP,                   4'b0000, 6'b101101},
    {mk(1,0,0,0,0,0,0,1,0), NOP,                   4'b1001, 6'b000101},
    {mk(1,0,0,0,0,0,0,0,1), NOP,                   4'b1011, 6'b110100},
    {NOP,                   NOP,                   4'b0000, 6'b100100},
    {NOP,                   NOP,                   4'b0000, 6'b000100},
    {NOP,                   NOP,                   4'b1100, 6'b000100},
    {NOP,                   NOP,                   4'b1001, 6'b000000}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_lane(input int l, input logic [14:0] w);
    {grp_valid[l], grp_use_a[l], grp_src_a[l], grp_use_b[l], grp_src_b[l],
     grp_wr_dst[l], grp_dst[l], grp_rd_flag[l], grp_wr_flag[l]} = w;
  endtask

  task automatic drive(input logic [14:0] l0, input logic [14:0] l1, input logic [3:0] w);
    set_lane(0, l0);
    set_lane(1, l1);
    {wb_valid, wb_tag, wb_wr_flag} = w;
  endtask

  task automatic step_disp(input string req, input int dv, input int dt);
    @(negedge clk);
    chk(req, int'(disp_valid), dv);
    if (dv != 0) chk(req, int'(disp_tag), dt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(NOP, NOP, 4'b0000);
    repeat (3) @(negedge clk);
    chk("R1 room", int'(grp_room), 1);
    chk("R1 disp", int'(disp_valid), 0);
    chk("R1 flag", int'(flag_busy), 0);
    rst_n = 1'b1;

    // Script: dependency chains, same-cycle capture, flag renaming, age order.
    for (int r = 0; r < NROWS; r++) begin
      drive(SCRIPT[r][39:25], SCRIPT[r][24:10], SCRIPT[r][9:6]);
      @(negedge clk);
      chk($sformatf("R3 R4 R5 R8 R9 disp_valid row %0d", r), int'(disp_valid), int'(SCRIPT[r][5]));
      if (SCRIPT[r][5])
        chk($sformatf("R9 disp_tag row %0d", r), int'(disp_tag), int'(SCRIPT[r][4:3]));
      chk($sformatf("R6 R7 flag_busy row %0d", r), int'(flag_busy), int'(SCRIPT[r][2]));
      if (SCRIPT[r][2])
        chk($sformatf("R7 flag_tag row %0d", r), int'(flag_tag), int'(SCRIPT[r][1:0]));
    end
    drive(NOP, NOP, 4'b0000);

    // R2: allocation order and room; lane order decides age.
    drive(mk(1,0,0,0,0,0,0,0,0), mk(1,0,0,0,0,0,0,0,0), 4'b0000);
    @(negedge clk);
    chk("R2 room after two", int'(grp_room), 1);
    chk("R2 lane0 takes slot 0", int'(disp_tag), 0);
    drive(mk(1,0,0,0,0,0,0,0,0), mk(1,0,0,0,0,0,0,0,0), 4'b0000);
    @(negedge clk);
    chk("R2 room when full", int'(grp_room), 0);
    chk("R9 lane1 after lane0", int'(disp_tag), 1);
    drive(NOP, NOP, 4'b0000);
    step_disp("R9 third", 1, 2);
    step_disp("R9 fourth", 1, 3);
    step_disp("R8 all held", 0, 0);
    for (int t = 0; t < 4; t++) begin
      drive(NOP, NOP, {1'b1, 2'(t), 1'b0});
      @(negedge clk);
    end
    drive(NOP, NOP, 4'b0000);
    chk("R10 room after release", int'(grp_room), 1);

    // R3: two writers of r3; the older one's broadcast leaves the tracker alone.
    drive(mk(1,0,0,0,0,1,3,0,0), NOP, 4'b0000);
    step_disp("R3 writer X", 1, 0);
    drive(mk(1,0,0,0,0,1,3,0,0), NOP, 4'b0000);
    step_disp("R3 writer Y", 1, 1);
    drive(NOP, NOP, 4'b0000);
    step_disp("R8 both held", 0, 0);
    drive(NOP, NOP, 4'b1000);
    step_disp("R10 X back", 0, 0);
    drive(mk(1,0,0,1,3,0,0,0,0), NOP, 4'b0000);
    step_disp("R3 reader waits on Y", 0, 0);
    drive(NOP, NOP, 4'b1010);
    step_disp("R5 reader woken", 1, 0);
    drive(NOP, NOP, 4'b0000);
    step_disp("R8 reader held", 0, 0);
    drive(NOP, NOP, 4'b1000);
    @(negedge clk);
    drive(NOP, NOP, 4'b0000);
    chk("R10 room at end", int'(grp_room), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule